// File: doc/BRIEF.md
# Command Queue Consumer and Decoder

This block drains a circular queue of 16-byte commands that software fills in memory. While the queue is switched on, error-free and not empty, it reads the entry under its consumer pointer one 32-bit word at a time over a request/acknowledge read port. It classifies the opcode and raises a one-cycle strobe on the output for that command class, together with the identifier, address and range fields taken from the entry. It then moves the consumer pointer on by one. The work that each command asks for, such as invalidating a cache, is left to downstream logic that listens to the strobes.

A command with an unknown opcode, or a word read that comes back aborted, stops the block on that entry. The consumer pointer keeps its position, and an error code sits in a field of the consumer register. A one-cycle global error pulse is raised, and nothing more is fetched until software clears the field. When it is cleared, the same entry is read again. A sync command can ask for no completion signal, for an interrupt pulse or for an event pulse. All earlier commands have already retired by the time it is decoded, so that pulse comes out together with its strobe.

Top module: `cq_consumer`

## Requirements
- R1: No read request starts while `cq_en` is low, while the queue is empty (the consumer index equals `prod_ptr`, wrap bit included), or while the error field is non-zero.
- R2: An entry is read as words 0, 1, 2, 3 in that order at `rd_entry` equal to the low index bits of the consumer pointer. `rd_req`, `rd_entry` and `rd_word` stay steady until `rd_ack`.
- R3: A legal command gives exactly one bit of `cls_stb` for one cycle. The opcode is word0[7:0]. Bit 0 is 0x01–0x07. Bit 1 is 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A and 0x30. Bit 2 is 0x40. Bit 3 is 0x41. Bit 4 is 0x44 or 0x45. Bit 5 is 0x46.
- R4: With the strobe come these fields. Stream ID is word1. VMID is word1[15:0] and ASID is word1[31:16]. Substream ID is word0[31:12] and its valid flag is word0[11]. NUM is word0[16:12] and SCALE is word0[24:20]. The address is {word3, word2[31:12], 12'h000}. TG is word2[11:10], TTL is word2[9:8], the leaf flag is word2[0] and the entry range is word2[4:0].
- R5: Each legal command advances the (IDX_W+1)-bit consumer pointer, held in `cons_reg[IDX_W:0]`, by one modulo 2^(IDX_W+1). This happens in the same cycle as its strobe.
- R6: An opcode outside the R3 list, 0x00 included, writes code 1 into `cons_reg[30:24]`. The pointer is not changed, no strobe is raised and `gerror` pulses for one cycle.
- R7: A read acknowledged with `rd_abort` writes code 2 into `cons_reg[30:24]`, keeps the pointer and pulses `gerror` for one cycle.
- R8: While the error field is non-zero, no entry is fetched. A one-cycle `err_clr` zeroes the field, and processing restarts at the entry that faulted.
- R9: On a sync (0x46), word0[13:12] equal to 1 pulses `sync_irq` and equal to 2 pulses `sync_evt`, both with the strobe. Values 0 and 3 pulse neither.
- R10: A completely full queue (2^IDX_W entries outstanding) is drained in order with the pointer wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cq_en | input | 1 | Command queue enable |
| prod_ptr | input | IDX_W+1 | Producer index with wrap bit |
| err_clr | input | 1 | Clears the error field |
| cons_reg | output | 32 | Consumer register: error code [30:24], index with wrap [IDX_W:0] |
| rd_req | output | 1 | Word read request |
| rd_entry | output | IDX_W | Entry index being read |
| rd_word | output | 2 | Word index within the entry |
| rd_ack | input | 1 | Read accepted, data valid |
| rd_abort | input | 1 | Read failed (valid with rd_ack) |
| rd_data | input | 32 | Read data |
| cls_stb | output | 6 | One-hot command class strobe |
| cmd_op | output | 8 | Opcode |
| cmd_sid | output | 32 | Stream ID |
| cmd_vmid | output | 16 | VMID |
| cmd_asid | output | 16 | ASID |
| cmd_ssid | output | 20 | Substream ID |
| cmd_ssv | output | 1 | Substream ID valid |
| cmd_addr | output | 64 | Address |
| cmd_tg | output | 2 | Granule field |
| cmd_ttl | output | 2 | Level hint |
| cmd_leaf | output | 1 | Leaf flag |
| cmd_num | output | 5 | Range NUM |
| cmd_scale | output | 5 | Range SCALE |
| cmd_range | output | 5 | Entry range |
| sync_irq | output | 1 | Sync interrupt pulse |
| sync_evt | output | 1 | Sync event pulse |
| gerror | output | 1 | Global error pulse |

## Verification
A fetch starts on the clock edge after the block sees a non-empty queue. With no read stalls, the strobe, fields, sync pulses, pointer update and error code all appear together one cycle after the fourth word is accepted. That is six edges after a push into an empty queue, and more when the bench withholds `rd_ack`. The bench stalls reads at random, so it does not count edges. It waits at falling edges for the first strobe or error pulse, with a bound. It then compares everything that changed at that edge against values worked out from the entry it wrote. One cycle later it checks that the pulses have dropped. Quiet windows of fixed length show that nothing happens while the block is disabled or halted.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int NUM_CLS   = 6;
  localparam int CLS_CFG   = 0;
  localparam int CLS_TLB   = 1;
  localparam int CLS_ATC   = 2;
  localparam int CLS_PRI   = 3;
  localparam int CLS_STALL = 4;
  localparam int CLS_SYNC  = 5;

  localparam logic [6:0] ERR_NONE    = 7'd0;
  localparam logic [6:0] ERR_ILLEGAL = 7'd1;
  localparam logic [6:0] ERR_ABORT   = 7'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DECODE} fetch_st_e;

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] sid;
    logic [19:0] ssid;
    logic        ssv;
    logic [63:0] addr;
    logic [1:0]  tg;
    logic [1:0]  ttl;
    logic        leaf;
    logic [4:0]  num;
    logic [4:0]  scale;
    logic [4:0]  range;
  } cmd_fields_t;

  // one-hot class of an opcode, all zero when illegal
  function automatic logic [NUM_CLS-1:0] classify(input logic [7:0] op);
    logic [NUM_CLS-1:0] c;
    c = '0;
    if (op >= 8'h01 && op <= 8'h07) c[CLS_CFG] = 1'b1;
    else if ((op >= 8'h10 && op <= 8'h13) || op == 8'h18 || op == 8'h1A ||
             (op >= 8'h20 && op <= 8'h23) || op == 8'h28 || op == 8'h2A ||
             op == 8'h30)
      c[CLS_TLB] = 1'b1;
    else if (op == 8'h40) c[CLS_ATC] = 1'b1;
    else if (op == 8'h41) c[CLS_PRI] = 1'b1;
    else if (op == 8'h44 || op == 8'h45) c[CLS_STALL] = 1'b1;
    else if (op == 8'h46) c[CLS_SYNC] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/cq_ptr.sv
module cq_ptr #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             set_err,
  input  logic [6:0]       err_code,
  input  logic             err_clr,
  output logic [IDX_W:0]   cons_idx,
  output logic             halted,
  output logic [31:0]      cons_reg
);
  localparam int PTR_W = IDX_W + 1;
  localparam int PAD_W = 24 - PTR_W;

  logic [PTR_W-1:0] idx_q;
  logic [6:0]       err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      err_q <= '0;
    end else begin
      if (adv) idx_q <= idx_q + 1'b1;
      // a new fault wins over a clear in the same cycle
      if (set_err)      err_q <= err_code;
      else if (err_clr) err_q <= cq_pkg::ERR_NONE;
    end
  end

  assign cons_idx = idx_q;
  assign halted   = (err_q != cq_pkg::ERR_NONE);
  assign cons_reg = {1'b0, err_q, {PAD_W{1'b0}}, idx_q};
endmodule

// File: rtl/cq_fetch.sv
module cq_fetch #(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cq_en,
  input  logic              halted,
  input  logic [IDX_W:0]    prod_idx,
  input  logic [IDX_W:0]    cons_idx,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_entry,
  output logic [1:0]        rd_word,
  input  logic              rd_ack,
  input  logic              rd_abort,
  input  logic [31:0]       rd_data,
  output logic [3:0][31:0]  words,
  output logic              dec_go,
  output logic              abort_hit
);
  import cq_pkg::*;

  fetch_st_e        st_q;
  logic [1:0]       wsel_q;
  logic [3:0][31:0] buf_q;
  logic             start;

  assign start = cq_en && !halted && (cons_idx != prod_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wsel_q <= '0;
      buf_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          wsel_q <= '0;
          if (start) st_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (rd_ack) begin
            if (rd_abort) begin
              st_q <= ST_IDLE;
            end else begin
              buf_q[wsel_q] <= rd_data;
              if (wsel_q == 2'd3) st_q <= ST_DECODE;
              else                wsel_q <= wsel_q + 2'd1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req    = (st_q == ST_FETCH);
  assign rd_entry  = cons_idx[IDX_W-1:0];
  assign rd_word   = wsel_q;
  assign words     = buf_q;
  assign dec_go    = (st_q == ST_DECODE);
  assign abort_hit = rd_req && rd_ack && rd_abort;
endmodule

// File: rtl/cq_decode.sv
module cq_decode (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go,
  input  logic [3:0][31:0]           words,
  output logic                       legal,
  output logic [cq_pkg::NUM_CLS-1:0] cls_stb,
  output cq_pkg::cmd_fields_t        fields,
  output logic                       sync_irq,
  output logic                       sync_evt
);
  import cq_pkg::*;

  logic [NUM_CLS-1:0] cls;
  cmd_fields_t        f;
  logic [1:0]         cs;
  logic               unused_bits;

  assign cls   = classify(words[0][7:0]);
  assign legal = |cls;
  assign cs    = words[0][13:12];

  always_comb begin
    f.op    = words[0][7:0];
    f.sid   = words[1];
    f.ssid  = words[0][31:12];
    f.ssv   = words[0][11];
    f.addr  = {words[3], words[2][31:12], 12'h000};
    f.tg    = words[2][11:10];
    f.ttl   = words[2][9:8];
    f.leaf  = words[2][0];
    f.num   = words[0][16:12];
    f.scale = words[0][24:20];
    f.range = words[2][4:0];
  end

  assign unused_bits = ^{words[0][10:8], words[2][7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_stb  <= '0;
      fields   <= '0;
      sync_irq <= 1'b0;
      sync_evt <= 1'b0;
    end else begin
      cls_stb  <= go ? cls : '0;
      sync_irq <= go && cls[CLS_SYNC] && (cs == 2'd1);
      sync_evt <= go && cls[CLS_SYNC] && (cs == 2'd2);
      if (go && legal) fields <= f;
    end
  end
endmodule

// File: rtl/cq_consumer.sv
module cq_consumer #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cq_en,
  input  logic [IDX_W:0]   prod_ptr,
  input  logic             err_clr,
  output logic [31:0]      cons_reg,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_entry,
  output logic [1:0]       rd_word,
  input  logic             rd_ack,
  input  logic             rd_abort,
  input  logic [31:0]      rd_data,
  output logic [5:0]       cls_stb,
  output logic [7:0]       cmd_op,
  output logic [31:0]      cmd_sid,
  output logic [15:0]      cmd_vmid,
  output logic [15:0]      cmd_asid,
  output logic [19:0]      cmd_ssid,
  output logic             cmd_ssv,
  output logic [63:0]      cmd_addr,
  output logic [1:0]       cmd_tg,
  output logic [1:0]       cmd_ttl,
  output logic             cmd_leaf,
  output logic [4:0]       cmd_num,
  output logic [4:0]       cmd_scale,
  output logic [4:0]       cmd_range,
  output logic             sync_irq,
  output logic             sync_evt,
  output logic             gerror
);
  import cq_pkg::*;

  logic [IDX_W:0]   cons_idx;
  logic             halted;
  logic [3:0][31:0] words;
  logic             dec_go;
  logic             abort_hit;
  logic             legal;
  logic             bad_cmd;
  logic             set_err;
  logic [6:0]       err_code;
  cmd_fields_t      fields;
  logic             gerror_q;

  cq_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst(rst), .cq_en(cq_en), .halted(halted),
    .prod_idx(prod_ptr), .cons_idx(cons_idx),
    .rd_req(rd_req), .rd_entry(rd_entry), .rd_word(rd_word),
    .rd_ack(rd_ack), .rd_abort(rd_abort), .rd_data(rd_data),
    .words(words), .dec_go(dec_go), .abort_hit(abort_hit)
  );

  cq_decode u_decode (
    .clk(clk), .rst(rst), .go(dec_go), .words(words),
    .legal(legal), .cls_stb(cls_stb), .fields(fields),
    .sync_irq(sync_irq), .sync_evt(sync_evt)
  );

  assign bad_cmd  = dec_go && !legal;
  assign set_err  = abort_hit || bad_cmd;
  assign err_code = abort_hit ? ERR_ABORT : ERR_ILLEGAL;

  cq_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .adv(dec_go && legal),
    .set_err(set_err), .err_code(err_code), .err_clr(err_clr),
    .cons_idx(cons_idx), .halted(halted), .cons_reg(cons_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) gerror_q <= 1'b0;
    else     gerror_q <= set_err;
  end

  assign gerror    = gerror_q;
  assign cmd_op    = fields.op;
  assign cmd_sid   = fields.sid;
  assign cmd_vmid  = fields.sid[15:0];
  assign cmd_asid  = fields.sid[31:16];
  assign cmd_ssid  = fields.ssid;
  assign cmd_ssv   = fields.ssv;
  assign cmd_addr  = fields.addr;
  assign cmd_tg    = fields.tg;
  assign cmd_ttl   = fields.ttl;
  assign cmd_leaf  = fields.leaf;
  assign cmd_num   = fields.num;
  assign cmd_scale = fields.scale;
  assign cmd_range = fields.range;
endmodule

// File: rtl/cq_consumer_chk.sv
module cq_consumer_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cq_en,
  input logic             rd_req,
  input logic             rd_ack,
  input logic [1:0]       rd_word,
  input logic [IDX_W-1:0] rd_entry,
  input logic [5:0]       cls_stb,
  input logic             gerror,
  input logic             sync_irq,
  input logic             sync_evt,
  input logic [31:0]      cons_reg
);
  localparam int PTR_W = IDX_W + 1;

  AST_CLS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cls_stb)); // R3
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(cq_en) && ($past(cons_reg[30:24]) == 7'd0)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_word) && $stable(rd_entry)); // R2
  AST_STB_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (|cls_stb) |-> cons_reg[PTR_W-1:0] == PTR_W'($past(cons_reg[PTR_W-1:0]) + 1'b1)); // R5
  AST_ERR_NO_STB: assert property (@(posedge clk) disable iff (rst)
    gerror |-> (cls_stb == 6'd0) && (cons_reg[30:24] != 7'd0)); // R6
  AST_ERR_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    gerror |-> cons_reg[PTR_W-1:0] == $past(cons_reg[PTR_W-1:0])); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    gerror |=> !gerror); // R6
  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (cons_reg[30:24] != 7'd0) && !rd_req |=> !rd_req); // R8
  AST_SYNC_SIG: assert property (@(posedge clk) disable iff (rst)
    (sync_irq || sync_evt) |-> cls_stb[5] && !(sync_irq && sync_evt)); // R9
endmodule

bind cq_consumer cq_consumer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cq_en(cq_en), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_word(rd_word), .rd_entry(rd_entry), .cls_stb(cls_stb),
  .gerror(gerror), .sync_irq(sync_irq), .sync_evt(sync_evt),
  .cons_reg(cons_reg)
);

// File: tb/cq_consumer_tb.sv
module cq_consumer_tb;
  localparam int IDX_W = 3;
  localparam int PTR_W = IDX_W + 1;
  localparam int NENT  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cq_en = 1'b0;
  logic err_clr = 1'b0;
  logic [PTR_W-1:0] prod = '0;
  logic [31:0] cons_reg;
  logic rd_req, rd_ack, rd_abort, cmd_ssv, cmd_leaf, sync_irq, sync_evt, gerror;
  logic [IDX_W-1:0] rd_entry;
  logic [1:0] rd_word, cmd_tg, cmd_ttl;
  logic [31:0] rd_data, cmd_sid;
  logic [5:0] cls_stb;
  logic [7:0] cmd_op;
  logic [15:0] cmd_vmid, cmd_asid;
  logic [19:0] cmd_ssid;
  logic [63:0] cmd_addr;
  logic [4:0] cmd_num, cmd_scale, cmd_range;

  always #10 clk = ~clk; // 50 MHz

  logic [31:0] mem [0:4*NENT-1];
  logic ack_en = 1'b1;
  logic abort_arm = 1'b0;
  logic [IDX_W-1:0] abort_ent = '0;
  logic [1:0] abort_wd = '0;

  assign rd_ack   = rd_req && ack_en;
  assign rd_abort = rd_ack && abort_arm && rd_entry == abort_ent && rd_word == abort_wd;
  assign rd_data  = mem[{rd_entry, rd_word}];

  cq_consumer #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .cq_en(cq_en), .prod_ptr(prod), .err_clr(err_clr),
    .cons_reg(cons_reg), .rd_req(rd_req), .rd_entry(rd_entry), .rd_word(rd_word),
    .rd_ack(rd_ack), .rd_abort(rd_abort), .rd_data(rd_data), .cls_stb(cls_stb),
    .cmd_op(cmd_op), .cmd_sid(cmd_sid), .cmd_vmid(cmd_vmid), .cmd_asid(cmd_asid),
    .cmd_ssid(cmd_ssid), .cmd_ssv(cmd_ssv), .cmd_addr(cmd_addr), .cmd_tg(cmd_tg),
    .cmd_ttl(cmd_ttl), .cmd_leaf(cmd_leaf), .cmd_num(cmd_num), .cmd_scale(cmd_scale),
    .cmd_range(cmd_range), .sync_irq(sync_irq), .sync_evt(sync_evt), .gerror(gerror)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [PTR_W-1:0] exp_cons = '0;
  logic [6:0] exp_err = '0;
  logic [1:0] wexp = '0;
  bit stall_rand = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] legal_ops [19] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
    8'h10, 8'h13, 8'h18, 8'h1A, 8'h20, 8'h23, 8'h28, 8'h2A, 8'h30, 8'h40, 8'h41, 8'h46};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_class(input logic [7:0] op);
    if (op inside {[8'h01:8'h07]}) return 0;
    if (op inside {[8'h10:8'h13], 8'h18, 8'h1A, [8'h20:8'h23], 8'h28, 8'h2A, 8'h30}) return 1;
    if (op == 8'h40) return 2;
    if (op == 8'h41) return 3;
    if (op == 8'h44 || op == 8'h45) return 4;
    if (op == 8'h46) return 5;
    return -1;
  endfunction

  function automatic logic [31:0] exp_reg();
    return (32'(exp_err) << 24) | 32'(exp_cons);
  endfunction

  // handshake monitor: R2 word order and entry
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_rand) ack_en = ($urandom % 4) != 0;
      else            ack_en = 1'b1;
      if (rd_req && ack_en) begin
        chk("R2 rd_entry/rd_word", {rd_entry, rd_word}, {exp_cons[IDX_W-1:0], wexp});
        if (abort_arm && rd_entry == abort_ent && rd_word == abort_wd) wexp = 2'd0;
        else wexp = wexp + 2'd1;
      end
    end
  end

  task automatic push(input logic [31:0] w0, w1, w2, w3);
    mem[{prod[IDX_W-1:0], 2'd0}] = w0;
    mem[{prod[IDX_W-1:0], 2'd1}] = w1;
    mem[{prod[IDX_W-1:0], 2'd2}] = w2;
    mem[{prod[IDX_W-1:0], 2'd3}] = w3;
    prod = prod + 1'b1;
  endtask

  task automatic push_rand(input bit allow_bad);
    logic [7:0] op;
    op = legal_ops[$urandom % 19];
    if (allow_bad && ($urandom % 8) == 0) op = 8'($urandom);
    push({$urandom % 32'h0100_0000, op} , $urandom, $urandom, $urandom);
  endtask

  task automatic expect_next();
    logic [31:0] w0, w1, w2, w3;
    logic [IDX_W-1:0] ix;
    int c;
    int t;
    t = 0;
    while (!(|cls_stb || gerror) && t < 400) begin @(negedge clk); t++; end
    if (t >= 400) begin
      chk("R3 event timeout", 1, 0);
      return;
    end
    ix = exp_cons[IDX_W-1:0];
    w0 = mem[{ix, 2'd0}]; w1 = mem[{ix, 2'd1}];
    w2 = mem[{ix, 2'd2}]; w3 = mem[{ix, 2'd3}];
    c = exp_class(w0[7:0]);
    if (abort_arm && abort_ent == ix) begin
      exp_err = 7'd2;
      chk("R7 gerror/strobe", {gerror, cls_stb}, {1'b1, 6'd0});
      chk("R7 cons_reg", cons_reg, exp_reg());
    end else if (c < 0) begin
      exp_err = 7'd1;
      chk("R6 gerror/strobe", {gerror, cls_stb}, {1'b1, 6'd0});
      chk("R6 cons_reg", cons_reg, exp_reg());
    end else begin
      exp_cons = exp_cons + 1'b1;
      chk("R3 class strobe", {gerror, cls_stb}, {1'b0, 6'(1 << c)});
      chk("R4 op/sid", {cmd_op, cmd_sid}, {w0[7:0], w1});
      chk("R4 vmid/asid/ssid/ssv", {cmd_vmid, cmd_asid, cmd_ssid, cmd_ssv},
          {w1[15:0], w1[31:16], w0[31:12], w0[11]});
      chk("R4 addr", cmd_addr, {w3, w2[31:12], 12'h000});
      chk("R4 tg/ttl/leaf/num/scale/range",
          {cmd_tg, cmd_ttl, cmd_leaf, cmd_num, cmd_scale, cmd_range},
          {w2[11:10], w2[9:8], w2[0], w0[16:12], w0[24:20], w2[4:0]});
      chk("R9 sync irq/evt", {sync_irq, sync_evt},
          {c == 5 && w0[13:12] == 2'd1, c == 5 && w0[13:12] == 2'd2});
      chk("R5 cons_reg", cons_reg, exp_reg());
    end
    @(negedge clk);
    chk("R3 one-cycle pulse", {gerror, cls_stb, sync_irq, sync_evt}, 0);
  endtask

  task automatic quiet(input int n, input string req);
    int ev;
    ev = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd_req || gerror || |cls_stb) ev++;
    end
    chk(req, {32'(ev), cons_reg}, {32'd0, exp_reg()});
  endtask

  task automatic clear_err();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    exp_err = '0;
    chk("R8 error cleared, pointer kept", cons_reg, exp_reg());
  endtask

  task automatic fix_entry();
    mem[{exp_cons[IDX_W-1:0], 2'd0}] = {24'h12345, 8'h03};
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4*NENT; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R1 reset outputs", {rd_req, gerror, cls_stb, sync_irq, sync_evt}, 0);
    chk("R5 reset cons_reg", cons_reg, 32'd0);

    // R1: disabled queue is not fetched
    push(32'h0000_0001, 32'hA5A5_0001, 32'h0000_0000, 32'h0);
    quiet(20, "R1 disabled queue idle");
    cq_en = 1'b1;
    expect_next();
    quiet(10, "R1 empty queue idle");

    // R9 sync completion variants
    for (int cs = 0; cs < 4; cs++) begin
      push(32'(cs) << 12 | 32'h46, 32'h1, 32'h0, 32'h0);
      expect_next();
    end
    // R4 directed field pattern
    push(32'hFABC_D811, 32'hDEAD_BEEF, 32'h1234_5FFF, 32'h8765_4321);
    expect_next();
    push(32'h0000_0044, 32'h0, 32'h0000_FFFF, 32'h0);
    expect_next();

    // R6 illegal opcode 0x00, then R8 halt and resume on same entry
    push(32'hFFFF_FF00, 32'h0, 32'h0, 32'h0);
    push(32'h0000_0010, 32'h7, 32'h0, 32'h0);
    expect_next();
    quiet(25, "R8 halted, no fetch");
    fix_entry();
    clear_err();
    expect_next();
    expect_next();

    // R7 read abort on word 2, then resume
    abort_arm = 1'b1; abort_ent = prod[IDX_W-1:0]; abort_wd = 2'd2;
    push(32'h0000_0041, 32'h55, 32'h0, 32'h0);
    expect_next();
    quiet(15, "R8 halted after abort");
    abort_arm = 1'b0;
    clear_err();
    expect_next();

    // R10 full queue with random stalls, pointer wraps
    stall_rand = 1'b1;
    cq_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NENT; i++) push_rand(1'b0);
    cq_en = 1'b1;
    for (int i = 0; i < NENT; i++) expect_next();
    chk("R10 drained full queue", cons_reg, exp_reg());

    // random mix including illegal opcodes
    for (int it = 0; it < 120; it++) begin
      int nb;
      nb = 1 + ($urandom % 3);
      for (int k = 0; k < nb; k++) push_rand(1'b1);
      for (int k = 0; k < nb; k++) begin
        expect_next();
        if (exp_err != 0) begin
          fix_entry();
          clear_err();
          expect_next();
        end
      end
    end
    quiet(10, "R1 idle after random run");
    done = 1'b1;
    finish_run();
  end
endmodule